// File: doc/BRIEF.md
# Block-Cipher Data Buffer Handshake

This block sits between a memory-mapped host and a 128-bit block cipher engine. It holds four 32-bit input words that the host writes and four 32-bit output words that the host reads. It remembers which input words have been written and which output words have been read, and the order of those accesses does not matter. From this it decides when the engine may take a new block and when a finished block may be stored.

In automatic mode the engine starts by itself as soon as all four input words are present. A finished result is held back, and the block reports a stall, until the host has read every word of the previous result. In manual mode the engine starts only on an explicit start pulse. A finished result always replaces the previous one, and a sticky flag records that an unread block was lost.

The cipher datapath is not part of this block. A start/done stub interface stands in for it: the engine holds `eng_done_i` high with its result until it sees `eng_ack_o`.

Top module: `cipher_buf_ctl`

## Requirements
- R1: After reset, `idle_o`=1, `input_ready_o`=1, `out_valid_o`=0, `stall_o`=0, `out_lost_o`=0 and `eng_start_o`=0.
- R2: Words are little-endian. Input word i drives bits [32i+31:32i] of `eng_din_o`. Reading output index i returns bits [32i+31:32i] of the accepted `eng_dout_i`.
- R3: In automatic mode (`manual_i`=0), `eng_start_o` pulses for one cycle in the cycle after the last of the four distinct input words is written, in any order. Writing one word again does not count as a second word.
- R4: `input_ready_o` is 0 while all four input words are written but not yet loaded. It is 1 again in the cycle after the load.
- R5: In automatic mode, while output is valid and unread, a done request from the engine is not acknowledged and `stall_o`=1. The request is acknowledged in the cycle after the last unread output word is read. No output is ever lost in this mode.
- R6: `out_valid_o` rises in the cycle after an acknowledge. It falls only once all four output words have been read, in any order. Repeated reads of the same word do not clear it.
- R7: In manual mode the engine never starts on a full input set alone. It starts only on `start_i` while idle, and `start_i` while busy is ignored.
- R8: In manual mode a done request is acknowledged at once even if output is unread. Overwriting unread output sets `out_lost_o`, and `stall_o` stays 0.
- R9: `out_lost_o` stays set until `ctrl_wr_i` pulses. `ctrl_wr_i` clears the lost flag, the output-valid flag and both word-tracking masks, so input words written before it do not count.
- R10: `idle_o` is 0 from the cycle after a start until the cycle after the acknowledge, including any stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| manual_i | input | 1 | 1 = manual mode, 0 = automatic mode |
| ctrl_wr_i | input | 1 | Control-register rewrite pulse; clears tracking |
| start_i | input | 1 | Manual start pulse |
| in_we_i | input | 1 | Input word write strobe |
| in_idx_i | input | 2 | Input word index |
| in_wdata_i | input | 32 | Input word data |
| out_re_i | input | 1 | Output word read strobe |
| out_idx_i | input | 2 | Output word index |
| out_rdata_o | output | 32 | Output word at `out_idx_i` |
| eng_start_o | output | 1 | One-cycle engine start; loads `eng_din_o` |
| eng_din_o | output | 128 | Input block to the engine |
| eng_done_i | input | 1 | Engine result pending (held until acknowledged) |
| eng_dout_i | input | 128 | Engine result block |
| eng_ack_o | output | 1 | Result accepted this cycle |
| idle_o | output | 1 | No block in flight |
| input_ready_o | output | 1 | Host may write the next input block |
| out_valid_o | output | 1 | Unread output present |
| stall_o | output | 1 | Result held back by unread output |
| out_lost_o | output | 1 | Sticky: unread output was overwritten |

## Verification
The embedded assertions check several properties on every cycle:
- A start always makes the block busy on the next cycle.
- A stall never coincides with an acknowledge and always keeps the block busy.
- An acknowledge always raises output-valid.
- The lost flag is sticky until a control write.
- Automatic mode can never set the lost flag.

Only the bench scenarios can show the following:
- The data path's word placement.
- That a start waits for four distinct words in a random order.
- That a stall is released by exactly the last unread word.
- That manual mode ignores a full input set and a start pulse given while busy.
- That a control write discards a partly written block.

// File: rtl/cipher_buf_ctl.sv
module cipher_buf_ctl #(
  parameter int WORDS = 4,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     manual_i,
  input  logic                     ctrl_wr_i,
  input  logic                     start_i,
  input  logic                     in_we_i,
  input  logic [$clog2(WORDS)-1:0] in_idx_i,
  input  logic [DW-1:0]            in_wdata_i,
  input  logic                     out_re_i,
  input  logic [$clog2(WORDS)-1:0] out_idx_i,
  output logic [DW-1:0]            out_rdata_o,
  output logic                     eng_start_o,
  output logic [WORDS*DW-1:0]      eng_din_o,
  input  logic                     eng_done_i,
  input  logic [WORDS*DW-1:0]      eng_dout_i,
  output logic                     eng_ack_o,
  output logic                     idle_o,
  output logic                     input_ready_o,
  output logic                     out_valid_o,
  output logic                     stall_o,
  output logic                     out_lost_o
);
  localparam logic [WORDS-1:0] ALL = '1;

  logic [DW-1:0]    in_buf  [WORDS];
  logic [DW-1:0]    out_buf [WORDS];
  logic [WORDS-1:0] in_mask, out_mask, in_bit, rd_bit;
  logic             busy, go;

  assign in_bit = WORDS'(in_we_i) << in_idx_i;
  assign rd_bit = WORDS'(out_re_i) << out_idx_i;

  assign go = !busy && (manual_i ? start_i : (in_mask == ALL));
  assign eng_start_o   = go;
  assign eng_ack_o     = busy && eng_done_i && (manual_i || !out_valid_o);
  assign stall_o       = busy && eng_done_i && !manual_i && out_valid_o;
  assign idle_o        = !busy;
  assign input_ready_o = (in_mask != ALL);
  assign out_rdata_o   = out_buf[out_idx_i];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign eng_din_o[i*DW +: DW] = in_buf[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                        in_buf[i] <= '0;
      else if (in_we_i && in_idx_i == i) in_buf[i] <= in_wdata_i;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         out_buf[i] <= '0;
      else if (eng_ack_o) out_buf[i] <= eng_dout_i[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_mask <= '0;
    else        in_mask <= ((go || ctrl_wr_i) ? '0 : in_mask) | in_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        out_mask <= '0;
    else if (eng_ack_o || ctrl_wr_i)   out_mask <= '0;
    else                               out_mask <= out_mask | rd_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         busy <= 1'b0;
    else if (go)        busy <= 1'b1;
    else if (eng_ack_o) busy <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                out_valid_o <= 1'b0;
    else if (ctrl_wr_i)                        out_valid_o <= 1'b0;
    else if (eng_ack_o)                        out_valid_o <= 1'b1;
    else if (out_re_i && (out_mask | rd_bit) == ALL) out_valid_o <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           out_lost_o <= 1'b0;
    else if (ctrl_wr_i)                   out_lost_o <= 1'b0;
    else if (eng_ack_o && out_valid_o)    out_lost_o <= 1'b1;

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !idle_o); // R10
  AST_STALL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !eng_ack_o); // R5
  AST_STALL_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !idle_o); // R5
  AST_AUTO_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_i && !out_lost_o |=> !out_lost_o); // R5
  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ack_o && !ctrl_wr_i |=> out_valid_o); // R6
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_lost_o && !ctrl_wr_i |=> out_lost_o); // R9
endmodule

// File: tb/cipher_buf_ctl_test.sv
module cipher_buf_ctl_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic         rst_n, manual, ctrl_wr, start, in_we, out_re, eng_done;
  logic [1:0]   in_idx, out_idx;
  logic [31:0]  in_wdata, out_rdata;
  logic [127:0] eng_din, eng_dout, stub_din;
  logic         eng_start, eng_ack, idle, in_rdy, out_valid, stall, lost;
  int checks = 0, fails = 0, starts = 0, stub_cnt = 0;

  cipher_buf_ctl uut (
    .clk(clk), .rst_n(rst_n), .manual_i(manual), .ctrl_wr_i(ctrl_wr),
    .start_i(start), .in_we_i(in_we), .in_idx_i(in_idx), .in_wdata_i(in_wdata),
    .out_re_i(out_re), .out_idx_i(out_idx), .out_rdata_o(out_rdata),
    .eng_start_o(eng_start), .eng_din_o(eng_din), .eng_done_i(eng_done),
    .eng_dout_i(eng_dout), .eng_ack_o(eng_ack), .idle_o(idle),
    .input_ready_o(in_rdy), .out_valid_o(out_valid), .stall_o(stall),
    .out_lost_o(lost));

  function automatic logic [127:0] ciph(input logic [127:0] x);
    return {x[63:0], x[127:64]} ^ 128'h5a5a_0f0f_c3c3_9696_1234_5678_9abc_def0;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin eng_done <= 1'b0; stub_cnt <= 0; eng_dout <= '0; stub_din <= '0; end
    else begin
      if (eng_start) begin stub_din <= eng_din; stub_cnt <= 3; starts <= starts + 1; end
      else if (stub_cnt > 1) stub_cnt <= stub_cnt - 1;
      else if (stub_cnt == 1) begin stub_cnt <= 0; eng_done <= 1'b1; eng_dout <= ciph(stub_din); end
      if (eng_ack) eng_done <= 1'b0;
    end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input int idx, input logic [31:0] d);
    in_we = 1'b1; in_idx = 2'(idx); in_wdata = d;
    tick();
    in_we = 1'b0;
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string req);
    out_re = 1'b1; out_idx = 2'(idx);
    #1 chk(req, 128'(out_rdata), 128'(exp));
    tick();
    out_re = 1'b0;
  endtask

  task automatic perm(output int o[4]);
    for (int i = 0; i < 4; i++) o[i] = i;
    for (int i = 3; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      int t = o[i]; o[i] = o[j]; o[j] = t;
    end
  endtask

  task automatic write_block(input logic [127:0] b);
    int o[4];
    perm(o);
    for (int k = 0; k < 4; k++) wr(o[k], b[32*o[k] +: 32]);
  endtask

  task automatic read_block(input logic [127:0] b);
    int o[4];
    perm(o);
    for (int k = 0; k < 4; k++) begin
      if (k == 3) chk("R6 valid before last read", 128'(out_valid), 128'd1);
      rd(o[k], b[32*o[k] +: 32], "R2 output word");
    end
    chk("R6 valid after all reads", 128'(out_valid), 128'd0);
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 20 && !out_valid; i++) tick();
  endtask

  task automatic ctrl(input logic m);
    manual = m; ctrl_wr = 1'b1; tick(); ctrl_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] a, b;
    int s0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; manual = 0; ctrl_wr = 0; start = 0; in_we = 0; out_re = 0;
    in_idx = 0; out_idx = 0; in_wdata = 0;
    repeat (2) tick();
    rst_n = 1'b1; tick();
    chk("R1 idle", 128'(idle), 128'd1);
    chk("R1 input_ready", 128'(in_rdy), 128'd1);
    chk("R1 out_valid", 128'(out_valid), 128'd0);
    chk("R1 stall", 128'(stall), 128'd0);
    chk("R1 lost", 128'(lost), 128'd0);
    chk("R1 start", 128'(eng_start), 128'd0);

    // R3, R4, R2, R10: random auto blocks
    for (int it = 0; it < 20; it++) begin
      a = rnd128();
      write_block(a);
      chk("R3 auto start", 128'(eng_start), 128'd1);
      chk("R4 ready low before load", 128'(in_rdy), 128'd0);
      tick();
      chk("R4 ready after load", 128'(in_rdy), 128'd1);
      chk("R10 busy", 128'(idle), 128'd0);
      chk("R2 input packing", stub_din, a);
      wait_valid();
      chk("R10 idle after ack", 128'(idle), 128'd1);
      read_block(ciph(a));
    end

    // R3: duplicate word does not complete the set
    wr(0, 32'h1); wr(0, 32'h2); wr(1, 32'h3); wr(2, 32'h4);
    tick();
    chk("R3 no start on duplicate", 128'(idle), 128'd1);
    chk("R3 ready still high", 128'(in_rdy), 128'd1);
    ctrl(1'b0);

    // R5: stall on unread output
    a = rnd128(); b = rnd128();
    write_block(a); tick(); wait_valid();
    write_block(b);
    repeat (6) tick();
    chk("R5 stall", 128'(stall), 128'd1);
    chk("R5 no ack", 128'(eng_ack), 128'd0);
    chk("R10 idle low while stalled", 128'(idle), 128'd0);
    chk("R5 old data kept", 128'(out_rdata), 128'(ciph(a) >> (32*out_idx)) & 128'hffffffff);
    read_block(ciph(a));
    tick();
    chk("R5 stall released", 128'(stall), 128'd0);
    chk("R6 new valid", 128'(out_valid), 128'd1);
    chk("R5 no loss in auto", 128'(lost), 128'd0);
    read_block(ciph(b));

    // R9: control write discards partial input
    wr(0, 32'hA); wr(1, 32'hB); wr(2, 32'hC);
    ctrl(1'b0);
    wr(3, 32'hD); tick();
    chk("R9 partial block discarded", 128'(idle), 128'd1);
    ctrl(1'b1);

    // R7: manual mode
    a = rnd128();
    write_block(a); repeat (4) tick();
    chk("R7 no auto start", 128'(idle), 128'd1);
    s0 = starts;
    start = 1'b1; tick(); start = 1'b0;
    chk("R7 manual start", 128'(idle), 128'd0);
    start = 1'b1; tick(); start = 1'b0;
    wait_valid();
    chk("R7 start while busy ignored", 128'(starts - s0), 128'd1);
    chk("R2 manual data", stub_din, a);

    // R8: overwrite unread output
    b = rnd128();
    write_block(b);
    start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (stall) chk("R8 no stall in manual", 128'(stall), 128'd0);
      tick();
    end
    chk("R8 lost set", 128'(lost), 128'd1);
    chk("R8 idle after overwrite", 128'(idle), 128'd1);
    rd(0, ciph(b)  [31:0], "R8 new data stored");
    repeat (3) tick();
    chk("R9 lost sticky", 128'(lost), 128'd1);
    ctrl(1'b1);
    chk("R9 lost cleared", 128'(lost), 128'd0);
    chk("R9 valid cleared", 128'(out_valid), 128'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule